// File: doc/BRIEF.md
# Sync Pulse Capture Input Conditioner

This block sits between two raw synchronisation pins and the event inputs of a microcontroller core. The horizontal-sync style pin feeds a timer/counter input. In capture mode the pin is width-filtered at a programmable polarity. Pulses that are too short are discarded. Each pulse that survives is widened to one full machine cycle, so that a counter sampling once per machine cycle always registers it. In standard mode the pin reaches the counter unchanged, apart from synchronisation. The vertical-sync style pin feeds an interrupt input, with optional inversion.

All behaviour is set by a three-bit control register that can only be written, at bus address E4h. The register resets to zero, so after reset both inputs behave in the standard way.

The block runs on one clock, `clk`. `samp_en` marks the sampling instants and must pulse at twice the oscillator rate. When `clk` itself runs at twice the oscillator rate, `samp_en` is tied high. A machine cycle is twelve oscillator periods, which is 24 sampling ticks.

Top module: `sync_pulse_cond`

## Requirements
- R1: After reset the control register is zero, `tcount_o` and `irq_line_o` are 1 while both pins are held high, and both outputs follow their pins.
- R2: Control bit 0 set makes `irq_line_o` the inverse of the synchronised vertical pin; a write takes effect at the clock edge that accepts it, and `irq_line_o` always equals the pin value from two clock edges earlier XOR bit 0.
- R3: With control bit 1 clear, `tcount_o` equals the horizontal pin value from two clock edges earlier (two-stage synchroniser, no filtering).
- R4: With bit 1 set and `samp_en` high, an active pulse lasting at most two clock cycles (two sampling ticks) produces no output pulse.
- R5: With bit 1 set, an active pulse covering three consecutive sampling ticks is accepted; with `samp_en` high, `tcount_o` goes low after the fifth clock edge counted from the first edge that sees the pin active.
- R6: An accepted pulse drives `tcount_o` low (active level 0, idle 1) for exactly 24 sampling ticks (one machine cycle).
- R7: Control bit 2 set selects high-going pulses as active, and bit 2 clear selects low-going pulses.
- R8: A pulse that stays active for a long time produces a single output pulse; the input must be seen inactive before another pulse can be accepted.
- R9: An acceptance during the stretched output or during the 24 following ticks is ignored. With `samp_en` high, two 3-cycle pulses 49 cycles apart give two output pulses, and pulses 48 cycles apart give one.
- R10: Writes to any address other than E4h leave the control register unchanged.
- R11: Filtering and stretching advance only on ticks with `samp_en` high. At half rate, a 4-cycle pulse is rejected, an 8-cycle pulse is accepted, and the stretched output lasts 48 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sampling tick, twice the oscillator rate |
| hsync_pin | input | 1 | Raw horizontal sync pin |
| vsync_pin | input | 1 | Raw vertical sync pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| tcount_o | output | 1 | Timer/counter event input |
| irq_line_o | output | 1 | Interrupt input line |

## Verification
The hardest situation to reach is a pulse accepted by the filter while the stretcher is still busy: either during the stretched output, or in the gap that follows it. The tick on which the stretcher goes idle is the exact boundary. The bench reaches it by sending pairs of minimum-width pulses at spacings of 48 and 49 cycles. The first pair's second acceptance falls on the last gap tick and must vanish. The second pair's acceptance falls one tick later and must produce a pulse. A spacing of 30 places the second acceptance inside the gap, and a half-rate `samp_en` run shows that only enabled ticks count.

// File: rtl/spc_pkg.sv
package spc_pkg;

   // Control register layout: bit 2 polarity, bit 1 capture, bit 0 invert
   typedef struct packed {
      logic pos_sel;      // 1: high-going pulses are active
      logic capture_en;   // 1: filtered/stretched path drives the counter
      logic irq_invert;   // 1: interrupt line inverted
   } spc_ctrl_t;

   localparam int CTRL_BITS = $bits(spc_ctrl_t);

   typedef enum logic [1:0] {
      STR_IDLE = 2'd0,
      STR_HOLD = 2'd1,
      STR_GAP  = 2'd2
   } spc_str_e;

   typedef enum logic {
      FLT_ARMED = 1'b0,
      FLT_SPENT = 1'b1
   } spc_flt_e;

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
   parameter int              STAGES  = 2,
   parameter int              WIDTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spc_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= g_stg[i-1].q;
         end
      end
   end

   assign q_o = g_stg[STAGES-1].q;

endmodule

// File: rtl/spc_ctrl_reg.sv
module spc_ctrl_reg
   import spc_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hE4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output spc_ctrl_t         ctrl_o
);

   if (DATA_W < CTRL_BITS) begin : g_bad_data
      $error("spc_ctrl_reg: DATA_W too narrow for control fields");
   end

   logic hit;
   assign hit = we_i && (addr_i == REG_ADDR);

   if (DATA_W > CTRL_BITS) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:CTRL_BITS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctrl_o <= '0;
      else if (hit) ctrl_o <= spc_ctrl_t'(wdata_i[CTRL_BITS-1:0]);
   end

endmodule

// File: rtl/spc_width_filter.sv
module spc_width_filter
   import spc_pkg::*;
#(
   parameter int RUN_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_en,
   input  logic act_i,
   output logic accept_o
);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("spc_width_filter: RUN_LEN must be at least 2");
   end

   localparam int             CW   = $clog2(RUN_LEN);
   localparam logic [CW-1:0]  LAST = CW'(RUN_LEN - 1);

   logic [CW-1:0] run_q;
   spc_flt_e      st_q;

   // Accept on the RUN_LEN-th consecutive active tick
   assign accept_o = samp_en && act_i && (st_q == FLT_ARMED) && (run_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         st_q  <= FLT_ARMED;
      end else if (samp_en) begin
         if (!act_i) begin
            run_q <= '0;
            st_q  <= FLT_ARMED;
         end else if (st_q == FLT_ARMED) begin
            if (run_q == LAST) begin
               run_q <= '0;
               st_q  <= FLT_SPENT;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spc_stretch.sv
module spc_stretch
   import spc_pkg::*;
#(
   parameter int HOLD_TICKS = 24,
   parameter int GAP_TICKS  = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_en,
   input  logic fire_i,
   output logic hold_o
);

   if (HOLD_TICKS < 2 || GAP_TICKS < 2) begin : g_bad_ticks
      $error("spc_stretch: HOLD_TICKS and GAP_TICKS must be at least 2");
   end

   localparam int            MAXT      = (HOLD_TICKS > GAP_TICKS) ? HOLD_TICKS : GAP_TICKS;
   localparam int            CW        = $clog2(MAXT);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
   localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_TICKS - 1);

   spc_str_e      st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= STR_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            STR_IDLE: begin
               if (fire_i) begin
                  st_q  <= STR_HOLD;
                  cnt_q <= '0;
               end
            end
            STR_HOLD: begin
               if (samp_en) begin
                  if (cnt_q == HOLD_LAST) begin
                     st_q  <= STR_GAP;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            STR_GAP: begin
               if (samp_en) begin
                  if (cnt_q == GAP_LAST) begin
                     st_q  <= STR_IDLE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               st_q  <= STR_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign hold_o = (st_q == STR_HOLD);

endmodule

// File: rtl/sync_pulse_cond.sv
module sync_pulse_cond
   import spc_pkg::*;
#(
   parameter int                OSC_PER_MC      = 12,
   parameter int                SAMPLES_PER_OSC = 2,
   parameter int                RUN_LEN         = 3,
   parameter int                SYNC_STAGES     = 2,
   parameter int                ADDR_W          = 8,
   parameter int                DATA_W          = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR        = 'hE4,
   parameter bit                CNT_ACTIVE_LOW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              hsync_pin,
   input  logic              vsync_pin,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              tcount_o,
   output logic              irq_line_o
);

   localparam int HOLD_TICKS = OSC_PER_MC * SAMPLES_PER_OSC;
   localparam int GAP_TICKS  = HOLD_TICKS;

   // A pulse under one oscillator period spans at most SAMPLES_PER_OSC ticks
   if (RUN_LEN <= SAMPLES_PER_OSC) begin : g_bad_filter
      $error("sync_pulse_cond: RUN_LEN must exceed SAMPLES_PER_OSC");
   end
   if (OSC_PER_MC < 1) begin : g_bad_mc
      $error("sync_pulse_cond: OSC_PER_MC must be positive");
   end

   spc_ctrl_t ctrl_q;
   logic      ctrl_cap;
   logic      ctrl_inv;
   logic      ctrl_pos;
   logic      h_s;
   logic      v_s;
   logic      act_w;
   logic      fire_w;
   logic      hold_w;
   logic      stretched;

   spc_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .ctrl_o  (ctrl_q)
   );

   assign ctrl_cap = ctrl_q.capture_en;
   assign ctrl_inv = ctrl_q.irq_invert;
   assign ctrl_pos = ctrl_q.pos_sel;

   spc_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (2),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({vsync_pin, hsync_pin}),
      .q_o   ({v_s, h_s})
   );

   assign act_w = ctrl_pos ? h_s : ~h_s;

   spc_width_filter #(
      .RUN_LEN (RUN_LEN)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .act_i    (act_w),
      .accept_o (fire_w)
   );

   spc_stretch #(
      .HOLD_TICKS (HOLD_TICKS),
      .GAP_TICKS  (GAP_TICKS)
   ) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp_en (samp_en),
      .fire_i  (fire_w),
      .hold_o  (hold_w)
   );

   if (CNT_ACTIVE_LOW) begin : g_act_low
      assign stretched = ~hold_w;
   end else begin : g_act_high
      assign stretched = hold_w;
   end

   assign tcount_o   = ctrl_cap ? stretched : h_s;
   assign irq_line_o = v_s ^ ctrl_inv;

endmodule

// File: rtl/sync_pulse_cond_chk.sv
module sync_pulse_cond_chk #(
   parameter int HOLD_TICKS = 24,
   parameter int GAP_TICKS  = 24,
   parameter int RUN_LEN    = 3
) (
   input logic clk,
   input logic rst_n,
   input logic samp_en,
   input logic hsync_pin,
   input logic vsync_pin,
   input logic tcount_o,
   input logic irq_line_o,
   input logic ctrl_cap,
   input logic ctrl_inv,
   input logic act_w,
   input logic fire_w,
   input logic hold_w
);

   localparam int CW = $clog2(HOLD_TICKS + GAP_TICKS + RUN_LEN + 2) + 1;

   logic [1:0]    warm;
   logic [CW-1:0] hold_len;
   logic [CW-1:0] gap_len;
   logic [CW-1:0] act_run;
   logic          seen_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm      <= '0;
         hold_len  <= '0;
         gap_len   <= '0;
         act_run   <= '0;
         seen_fall <= 1'b0;
      end else begin
         if (warm != 2'd3) warm <= warm + 2'd1;
         if (!hold_w)      hold_len <= '0;
         else if (samp_en) hold_len <= hold_len + 1'b1;
         if (hold_w) gap_len <= '0;
         else if (samp_en && gap_len <= CW'(GAP_TICKS)) gap_len <= gap_len + 1'b1;
         if (!hold_w && hold_len != '0) seen_fall <= 1'b1;
         if (samp_en) begin
            if (!act_w) act_run <= '0;
            else if (act_run < CW'(RUN_LEN)) act_run <= act_run + 1'b1;
         end
      end
   end

   // R2: interrupt line is the pin two edges back, optionally inverted
   assert_irq_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (irq_line_o == ($past(vsync_pin, 2) ^ ctrl_inv)));

   // R3: standard mode passes the synchronised pin
   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm == 2'd3) && !ctrl_cap) |-> (tcount_o == $past(hsync_pin, 2)));

   // R4: acceptance only after RUN_LEN-1 earlier consecutive active ticks
   assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire_w |-> (act_run >= CW'(RUN_LEN - 1)));

   // R6: stretched output lasts exactly one machine cycle of ticks
   assert_stretch_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_w) |-> (hold_len == CW'(HOLD_TICKS)));

   // R9: inactive spacing between stretched pulses
   assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hold_w) && seen_fall) |-> (gap_len >= CW'(GAP_TICKS)));

endmodule

bind sync_pulse_cond sync_pulse_cond_chk #(
   .HOLD_TICKS (HOLD_TICKS),
   .GAP_TICKS  (GAP_TICKS),
   .RUN_LEN    (RUN_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .samp_en    (samp_en),
   .hsync_pin  (hsync_pin),
   .vsync_pin  (vsync_pin),
   .tcount_o   (tcount_o),
   .irq_line_o (irq_line_o),
   .ctrl_cap   (ctrl_cap),
   .ctrl_inv   (ctrl_inv),
   .act_w      (act_w),
   .fire_w     (fire_w),
   .hold_w     (hold_w)
);

// File: tb/sync_pulse_cond_tb.sv
module sync_pulse_cond_tb;

   localparam int OSC_PER_MC = 12;
   localparam int SPO        = 2;
   localparam int RUN        = 3;
   localparam int SYNC       = 2;
   localparam int HOLD       = OSC_PER_MC * SPO;   // 24 ticks
   localparam int LAT        = SYNC + RUN;         // first low at edge 5

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b1;
   logic       en_half = 1'b0;
   logic       hsync_pin = 1'b1;
   logic       vsync_pin = 1'b1;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic       tcount_o;
   logic       irq_line_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int n_pulses, first_at, first_len, second_at;

   always #2 clk = ~clk;

   always @(negedge clk) samp_en <= en_half ? ~samp_en : 1'b1;

   sync_pulse_cond u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_en    (samp_en),
      .hsync_pin  (hsync_pin),
      .vsync_pin  (vsync_pin),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .tcount_o   (tcount_o),
      .irq_line_o (irq_line_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // Drive one or two pulses from a negedge and record the counter output
   task automatic run_train(input int width, input int spacing, input int window,
                            input logic lvl);
      logic prev, o;
      n_pulses = 0; first_at = -1; first_len = 0; second_at = -1;
      @(negedge clk);
      prev = tcount_o;
      hsync_pin = lvl;
      for (int i = 1; i <= window; i++) begin
         @(negedge clk);
         o = tcount_o;
         if (prev && !o) begin
            n_pulses++;
            if (first_at < 0) first_at = i;
            else if (second_at < 0) second_at = i;
         end
         if (!o && n_pulses == 1) first_len++;
         prev = o;
         if (i == width) hsync_pin = ~lvl;
         if (spacing > 0 && i == spacing) hsync_pin = lvl;
         if (spacing > 0 && i == spacing + width) hsync_pin = ~lvl;
      end
      hsync_pin = ~lvl;
   endtask

   task automatic enter_capture(input logic [7:0] d, input logic idle);
      write_reg(8'hE4, 8'h00);
      hsync_pin = idle;
      repeat (60) @(negedge clk);
      write_reg(8'hE4, d);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(tcount_o == 1'b1, "R1", "tcount after reset", tcount_o, 1);
      chk(irq_line_o == 1'b1, "R1", "irq after reset", irq_line_o, 1);
      vsync_pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(irq_line_o == 1'b0, "R1", "irq follows pin", irq_line_o, 0);
      vsync_pin = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_bypass;
      @(negedge clk);
      hsync_pin = 1'b0;
      @(negedge clk);
      chk(tcount_o == 1'b1, "R3", "bypass after one edge", tcount_o, 1);
      @(negedge clk);
      chk(tcount_o == 1'b0, "R3", "bypass after two edges", tcount_o, 0);
      hsync_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(tcount_o == 1'b1, "R3", "bypass return high", tcount_o, 1);
   endtask

   task automatic t_invert;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'hE4; reg_wdata = 8'h01;
      chk(irq_line_o == 1'b1, "R2", "irq before write edge", irq_line_o, 1);
      @(negedge clk);
      reg_we = 1'b0;
      chk(irq_line_o == 1'b0, "R2", "irq inverted after edge", irq_line_o, 0);
      write_reg(8'hE4, 8'h00);
      chk(irq_line_o == 1'b1, "R2", "irq restored", irq_line_o, 1);
   endtask

   task automatic t_addr;
      write_reg(8'hE5, 8'h07);
      write_reg(8'h64, 8'h07);
      @(negedge clk);
      chk(irq_line_o == 1'b1, "R10", "irq after foreign write", irq_line_o, 1);
      hsync_pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(tcount_o == 1'b0, "R10", "still bypass after foreign write", tcount_o, 0);
      hsync_pin = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reject;
      enter_capture(8'h02, 1'b1);
      run_train(1, 0, 50, 1'b0);
      chk(n_pulses == 0, "R4", "1-cycle pulse", n_pulses, 0);
      run_train(2, 0, 50, 1'b0);
      chk(n_pulses == 0, "R4", "2-cycle pulse", n_pulses, 0);
   endtask

   task automatic t_accept;
      run_train(3, 0, 70, 1'b0);
      chk(n_pulses == 1, "R5", "3-cycle pulse count", n_pulses, 1);
      chk(first_at == LAT, "R5", "latency", first_at, LAT);
      chk(first_len == HOLD, "R6", "stretch length", first_len, HOLD);
      run_train(4, 0, 70, 1'b0);
      chk(first_len == HOLD, "R6", "stretch length 4-cycle", first_len, HOLD);
   endtask

   task automatic t_long;
      run_train(100, 0, 180, 1'b0);
      chk(n_pulses == 1, "R8", "long pulse counted once", n_pulses, 1);
   endtask

   task automatic t_spacing;
      run_train(3, 49, 120, 1'b0);
      chk(n_pulses == 2, "R9", "spacing 49 count", n_pulses, 2);
      chk(second_at == 49 + LAT, "R9", "spacing 49 second", second_at, 49 + LAT);
      repeat (60) @(negedge clk);
      run_train(3, 48, 120, 1'b0);
      chk(n_pulses == 1, "R9", "spacing 48 ignored", n_pulses, 1);
      repeat (60) @(negedge clk);
      run_train(3, 30, 120, 1'b0);
      chk(n_pulses == 1, "R9", "spacing 30 ignored", n_pulses, 1);
      repeat (60) @(negedge clk);
   endtask

   task automatic t_polarity;
      enter_capture(8'h06, 1'b0);
      run_train(3, 0, 70, 1'b1);
      chk(n_pulses == 1, "R7", "positive pulse accepted", n_pulses, 1);
      chk(first_at == LAT, "R7", "positive latency", first_at, LAT);
      run_train(2, 0, 50, 1'b1);
      chk(n_pulses == 0, "R7", "short positive rejected", n_pulses, 0);
   endtask

   task automatic t_half;
      enter_capture(8'h02, 1'b1);
      en_half = 1'b1;
      repeat (4) @(negedge clk);
      run_train(4, 0, 60, 1'b0);
      chk(n_pulses == 0, "R11", "half-rate 4-cycle rejected", n_pulses, 0);
      run_train(8, 0, 160, 1'b0);
      chk(n_pulses == 1, "R11", "half-rate 8-cycle accepted", n_pulses, 1);
      chk(first_len == 2 * HOLD, "R11", "half-rate length", first_len, 2 * HOLD);
      en_half = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bypass();
      t_invert();
      t_addr();
      t_reject();
      t_accept();
      t_long();
      t_spacing();
      t_polarity();
      t_half();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule